// File: doc/BRIEF.md
# Overvoltage Protection Sequencing Controller

This block is the digital sequencer behind an input protection switch. It watches two comparator results, one saying the supply is below the undervoltage level and one saying it is above the overvoltage level, plus an active-low enable. From these it decides when to turn on the external pass transistor through a gate-enable output, and when to release an active-low fault flag. Each asynchronous input passes through a two-flop synchroniser before the state machine uses it.

Power-up is a two-stage timed start. The supply must be inside the valid window and the enable must be low. The controller then waits a startup delay of DELAY_TICKS pulses of a millisecond tick input, and only then turns the gate on. The flag stays asserted for a further BLANK_TICKS tick pulses with the gate already on, and only then is the flag released. Overvoltage shuts the gate off with no filtering, from any state. Undervoltage sends the controller back to standby. Driving the enable high forces the gate off. An abort during either timed phase restarts the full timing from zero. A status output reports the state encoding for observation.

Top module: `ovp_seq_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, state_o is 0 (standby), gate_on is 0 and flag_n is 0.
- R2: If uv_in is high, the controller goes to standby (state_o 0) with gate_on 0 and flag_n 0 on the third rising edge after the change, whatever ov_in or en_n_in are doing. Undervoltage takes priority over every other input.
- R3: If ov_in is high and uv_in is low, the controller goes to fault (state_o 4) with gate_on 0 and flag_n 0 on the third rising edge after the change, from any state.
- R4: With no fault present, en_n_in high puts the controller in standby (state_o 0) with gate_on 0 and flag_n 0 on the third rising edge after the change.
- R5: When the synchronised inputs show the valid window and enable low, a controller in standby or fault enters delay (state_o 1) on the next edge. In delay, gate_on is 0 and flag_n is 0.
- R6: In delay, the controller moves to startup (state_o 2, gate_on 1, flag_n 0) on the edge at which it samples its DELAY_TICKS-th tick pulse counted since it entered delay. It stays in delay after fewer pulses.
- R7: In startup, the controller moves to on (state_o 3, gate_on 1, flag_n 1) on the edge at which it samples its BLANK_TICKS-th tick pulse counted since it entered startup.
- R8: A fault or a disable during delay or startup aborts the sequence. Once the conditions are valid again, the full DELAY_TICKS count restarts from zero.
- R9: A low enable never clears an active fault. While ov_in stays high the controller stays in fault (state_o 4) with gate_on 0, whatever en_n_in does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle millisecond tick pulse, synchronous to clk |
| uv_in | input | 1 | Comparator result: input below the undervoltage level (asynchronous) |
| ov_in | input | 1 | Comparator result: input above the overvoltage level (asynchronous) |
| en_n_in | input | 1 | Active-low enable (asynchronous) |
| gate_on | output | 1 | High turns the external gate drive on |
| flag_n | output | 1 | Active-low fault flag |
| state_o | output | 3 | State: 0 standby, 1 delay, 2 startup, 3 on, 4 fault |

## Verification
The assertions check on every cycle that the state machine obeys its priorities on the synchronised inputs. Undervoltage always leads to standby, overvoltage to fault, and a disable to standby. They also check that startup is only ever entered from delay, and on from startup, on a tick, and that the tick counter never runs past its limit. Only the bench scenarios can show the values that span many cycles. These are the exact number of tick pulses before the gate turns on and before the flag is released, the restart from zero after an abort, the three-edge latency through the synchronisers, and a fault that persists while enable is held low.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  typedef enum logic [2:0] {
    ST_STANDBY = 3'd0,
    ST_DELAY   = 3'd1,
    ST_STARTUP = 3'd2,
    ST_ON      = 3'd3,
    ST_FAULT   = 3'd4
  } ovp_state_e;
endpackage

// File: rtl/ovp_sync.sv
module ovp_sync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // two flops per bit; reset values chosen per bit by the parent
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[b];
        stab_q <= RST_VAL[b];
      end else begin
        meta_q <= d_i[b];
        stab_q <= meta_q;
      end
    end
    assign q_o[b] = stab_q;
  end
endmodule

// File: rtl/ovp_tick_timer.sv
module ovp_tick_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;

  assign expire_o = run_i && tick_i && (count_q == limit_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (!run_i || expire_o) begin
      count_q <= '0;
    end else if (tick_i) begin
      count_q <= count_q + 1'b1;
    end
  end

  // R6 / R7: the count never reaches the limit of the running phase
  assert_count_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (count_q < limit_i));
endmodule

// File: rtl/ovp_seq_fsm.sv
module ovp_seq_fsm
  import ovp_pkg::*;
#(
  parameter int DELAY_TICKS = 50,
  parameter int BLANK_TICKS = 50,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             uv_s,
  input  logic             ov_s,
  input  logic             en_n_s,
  input  logic             expire_i,
  output logic             run_o,
  output logic [CNT_W-1:0] limit_o,
  output ovp_state_e       state_o
);
  localparam logic [CNT_W-1:0] DLY_LIM = CNT_W'(DELAY_TICKS);
  localparam logic [CNT_W-1:0] BLK_LIM = CNT_W'(BLANK_TICKS);

  ovp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (uv_s) begin
      state_d = ST_STANDBY;
    end else if (ov_s) begin
      state_d = ST_FAULT;
    end else if (en_n_s) begin
      state_d = ST_STANDBY;
    end else begin
      unique case (state_q)
        ST_STANDBY, ST_FAULT: state_d = ST_DELAY;
        ST_DELAY:   if (expire_i) state_d = ST_STARTUP;
        ST_STARTUP: if (expire_i) state_d = ST_ON;
        ST_ON:      state_d = ST_ON;
        default:    state_d = ST_STANDBY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_STANDBY;
    else        state_q <= state_d;
  end

  assign run_o   = (state_q == ST_DELAY) || (state_q == ST_STARTUP);
  assign limit_o = (state_q == ST_DELAY) ? DLY_LIM : BLK_LIM;
  assign state_o = state_q;

  assert_uv_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uv_s |=> (state_q == ST_STANDBY));
  assert_ov_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_s && ov_s) |=> (state_q == ST_FAULT));
  assert_disable_standby_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_s && !ov_s && en_n_s) |=> (state_q == ST_STANDBY));
  assert_startup_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STARTUP && $past(state_q) != ST_STARTUP)
      |-> ($past(state_q) == ST_DELAY && $past(tick_i)));
  assert_on_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ON && $past(state_q) != ST_ON)
      |-> ($past(state_q) == ST_STARTUP && $past(tick_i)));
endmodule

// File: rtl/ovp_seq_ctrl.sv
module ovp_seq_ctrl
  import ovp_pkg::*;
#(
  parameter int DELAY_TICKS = 50,
  parameter int BLANK_TICKS = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       uv_in,
  input  logic       ov_in,
  input  logic       en_n_in,
  output logic       gate_on,
  output logic       flag_n,
  output logic [2:0] state_o
);
  localparam int MAX_TICKS = (DELAY_TICKS > BLANK_TICKS) ? DELAY_TICKS : BLANK_TICKS;
  localparam int CNT_W = $clog2(MAX_TICKS + 1);

  logic [2:0] raw_in, sync_q;
  logic uv_s, ov_s, en_n_s;
  logic run, expire;
  logic [CNT_W-1:0] limit;
  ovp_state_e st;

  assign raw_in = {uv_in, ov_in, en_n_in};

  // reset values: undervoltage assumed, no overvoltage, disabled
  ovp_sync #(.WIDTH(3), .RST_VAL(3'b101)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_q)
  );
  assign uv_s   = sync_q[2];
  assign ov_s   = sync_q[1];
  assign en_n_s = sync_q[0];

  ovp_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick),
    .limit_i(limit), .expire_o(expire)
  );

  ovp_seq_fsm #(
    .DELAY_TICKS(DELAY_TICKS), .BLANK_TICKS(BLANK_TICKS), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .uv_s(uv_s), .ov_s(ov_s),
    .en_n_s(en_n_s), .expire_i(expire), .run_o(run), .limit_o(limit),
    .state_o(st)
  );

  assign gate_on = (st == ST_STARTUP) || (st == ST_ON);
  assign flag_n  = (st == ST_ON);
  assign state_o = st;

  // R9: a gate that is on implies no fault was seen on the previous edge
  assert_gate_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> ($past(!uv_s) && $past(!ov_s) && $past(!en_n_s)));
endmodule

// File: tb/tb_ovp_seq_ctrl.sv
module tb_ovp_seq_ctrl;
  localparam int DLY = 5;
  localparam int BLK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, uv_in = 1'b1, ov_in = 1'b0, en_n_in = 1'b1;
  logic gate_on, flag_n;
  logic [2:0] state_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ovp_seq_ctrl #(.DELAY_TICKS(DLY), .BLANK_TICKS(BLK)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .uv_in(uv_in), .ov_in(ov_in),
    .en_n_in(en_n_in), .gate_on(gate_on), .flag_n(flag_n), .state_o(state_o)
  );

  // expected outputs for a state code, from R1..R7
  function automatic logic [4:0] exp_out(input logic [2:0] s);
    logic g, f;
    g = (s == 3'd2) || (s == 3'd3);
    f = (s == 3'd3);
    return {g, f, s};
  endfunction

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'd0: return "R2/R4";
      3'd1: return "R5/R8";
      3'd2: return "R6";
      3'd3: return "R7";
      default: return "R3/R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [2:0] exp_state);
    logic [4:0] act, expv;
    act  = {gate_on, flag_n, state_o};
    expv = exp_out(exp_state);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: {gate,flag_n,state} actual=%b expected=%b at %0t", tag, act, expv, $time);
    end
  endtask

  // requirement-level reference model
  logic [2:0] m1, m2, mstate;
  int mcnt;
  bit model_on = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 3'b101; m2 <= 3'b101; mstate <= 3'd0; mcnt <= 0;
    end else begin
      m1 <= {uv_in, ov_in, en_n_in};
      m2 <= m1;
      if (m2[2])      begin mstate <= 3'd0; mcnt <= 0; end
      else if (m2[1]) begin mstate <= 3'd4; mcnt <= 0; end
      else if (m2[0]) begin mstate <= 3'd0; mcnt <= 0; end
      else begin
        case (mstate)
          3'd0, 3'd4: begin mstate <= 3'd1; mcnt <= 0; end
          3'd1: if (tick) begin
                  if (mcnt + 1 == DLY) begin mstate <= 3'd2; mcnt <= 0; end
                  else mcnt <= mcnt + 1;
                end
          3'd2: if (tick) begin
                  if (mcnt + 1 == BLK) begin mstate <= 3'd3; mcnt <= 0; end
                  else mcnt <= mcnt + 1;
                end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n && !finished) chk(tag_of(mstate), mstate);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    cyc(2);
    chk("R1 in reset", 3'd0);
    @(negedge clk); rst_n = 1'b1;
    cyc(1);
    chk("R1 after reset", 3'd0);
    model_on = 1;

    uv_in = 1'b0; en_n_in = 1'b0;
    cyc(2); chk("R5 not yet", 3'd0);
    cyc(1); chk("R5 delay", 3'd1);
    pulse(DLY - 1); chk("R6 short of count", 3'd1);
    pulse(1); chk("R6 gate on", 3'd2);
    pulse(BLK - 1); chk("R7 blanking", 3'd2);
    pulse(1); chk("R7 on", 3'd3);

    ov_in = 1'b1;
    cyc(2); chk("R3 latency", 3'd3);
    cyc(1); chk("R3 fault", 3'd4);
    en_n_in = 1'b1; cyc(4); en_n_in = 1'b0; cyc(6);
    chk("R9 fault held", 3'd4);
    pulse(DLY + 1); chk("R9 fault ignores ticks", 3'd4);

    ov_in = 1'b0; cyc(3); chk("R5 from fault", 3'd1);
    pulse(3);
    en_n_in = 1'b1; cyc(3); chk("R4 disable", 3'd0);
    en_n_in = 1'b0; cyc(3); chk("R8 restart delay", 3'd1);
    pulse(DLY - 1); chk("R8 full count again", 3'd1);
    pulse(1); chk("R8 gate on after full count", 3'd2);
    pulse(2);
    uv_in = 1'b1; ov_in = 1'b1; cyc(3); chk("R2 priority", 3'd0);
    ov_in = 1'b0; cyc(5); chk("R2 standby held", 3'd0);

    // constrained random: mostly valid window, occasional faults
    for (int i = 0; i < 6000; i++) begin
      tick = ($urandom % 3) == 0;
      if (($urandom % 40) == 0) uv_in = ($urandom % 4) == 0;
      if (($urandom % 50) == 0) ov_in = ($urandom % 4) == 0;
      if (($urandom % 45) == 0) en_n_in = ($urandom % 5) == 0;
      @(negedge clk);
    end
    tick = 1'b0;
    cyc(2);
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule